// File: doc/BRIEF.md
# Nibble-Prefix Instruction Decoder

This block turns a stream of one-byte instructions into decoded records. Every byte carries a 4-bit function code in bits [7:4] and a 4-bit data nibble in bits [3:0]. The data nibble is merged into a 32-bit operand register. Two function codes serve only to grow that register across several bytes: prefix (0x2) and negative prefix (0x6). Any other function code completes an instruction. It yields one record that holds the function code and the merged operand, and the operand register then starts again from zero. Function code 0xF is the operate escape. For that code the merged operand is a secondary operation code and not an immediate, and the record marks it with a flag.

Bytes arrive on a valid/ready input and records leave on a valid/ready output. One output register holds the current record. A new byte is taken only when that register is empty or is being drained in the same cycle.

The controller is a three-state machine. IDLE means no record is held and the operand register is clear. CHAIN means no record is held and a prefix has been absorbed. FULL means a record is held. The transitions are as follows. IDLE or CHAIN go to FULL on an accepted completing byte, and to CHAIN on an accepted prefix. FULL stays FULL while stalled, or when the record drains and a completing byte is taken at once. FULL goes to CHAIN when it drains and takes a prefix, and to IDLE when it drains and no byte is taken.

Top module: `nibdec_top`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the operand register is clear, so the first completing byte carries only its own nibble.
- R2: An accepted byte whose bits [7:4] are neither 0x2 nor 0x6, with no prefix pending, gives a record one cycle later: out_func = bits [7:4] and out_operand = bits [3:0] zero-extended.
- R3: An accepted byte with bits [7:4] = 0x2 gives no record. The operand register becomes (register OR nibble) shifted left by 4.
- R4: An accepted byte with bits [7:4] = 0x6 gives no record. The operand register becomes the bitwise complement of (register OR nibble), shifted left by 4.
- R5: Prefixes chain without limit. Bits shifted above bit 31 are discarded.
- R6: For function code 0xF, out_is_op is 1 and out_operand carries the secondary operation code. For every other code, out_is_op is 0.
- R7: A completing byte outputs (register OR nibble) and clears the operand register in the same cycle.
- R8: While out_valid is 1 and out_ready is 0, the record stays stable, in_ready is 0 and no byte is taken.
- R9: A record is consumed when out_valid and out_ready are both 1. out_valid then falls one cycle later unless a completing byte was accepted in that same cycle.
- R10: in_ready is 1 whenever out_ready is 1, so one record can pass per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction byte offered |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| in_byte | input | 8 | Function code [7:4], data nibble [3:0] |
| out_valid | output | 1 | Record held |
| out_ready | input | 1 | Consumer takes the record |
| out_func | output | 4 | Function code of the completed instruction |
| out_operand | output | 32 | Merged operand, or secondary code when out_is_op is 1 |
| out_is_op | output | 1 | Record is an operate escape |

## Verification
If the operand register is not cleared after a record, or a prefix is lost or doubled, the error appears in the out_operand of the very next record. That record can be many bytes later when a long prefix chain is being built. If the state machine and the output register fall out of step, a record is duplicated or dropped, or a byte is accepted during a stall. The bench catches this when a record is consumed, by matching each consumed record in order against a model queue. For that reason random stalls on out_ready are mixed with long runs of prefix and negative-prefix bytes.

// File: rtl/nibdec_pkg.sv
package nibdec_pkg;

    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] fcode_t;

    localparam fcode_t FC_PFIX = 4'h2;
    localparam fcode_t FC_NFIX = 4'h6;
    localparam fcode_t FC_OPER = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHAIN,
        ST_FULL
    } dec_state_e;

    typedef enum logic [1:0] {
        BK_PFIX,
        BK_NFIX,
        BK_PRIM,
        BK_OPER
    } byte_kind_e;

    function automatic byte_kind_e classify(input fcode_t f);
        byte_kind_e k;
        if (f == FC_PFIX)      k = BK_PFIX;
        else if (f == FC_NFIX) k = BK_NFIX;
        else if (f == FC_OPER) k = BK_OPER;
        else                   k = BK_PRIM;
        return k;
    endfunction

endpackage

// File: rtl/nibdec_oper.sv
module nibdec_oper
    import nibdec_pkg::*;
#(
    parameter int OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  byte_kind_e        kind,
    input  logic [NIB_W-1:0]  nib,
    output logic [OPND_W-1:0] merged
);

    localparam int PAD_W = OPND_W - NIB_W;

    logic [OPND_W-1:0] oreg_q;
    logic [OPND_W-1:0] oreg_d;

    assign merged = oreg_q | {{PAD_W{1'b0}}, nib};

    always_comb begin
        oreg_d = oreg_q;
        if (take) begin
            unique case (kind)
                BK_PFIX: oreg_d = merged << NIB_W;
                BK_NFIX: oreg_d = (~merged) << NIB_W;
                default: oreg_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oreg_q <= '0;
        else        oreg_q <= oreg_d;
    end

    // R7: a completing byte leaves the register empty
    p_oreg_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take && (kind == BK_PRIM || kind == BK_OPER) |=> oreg_q == '0);

    // R5: bits only move upward, the register keeps its contents while idle
    p_oreg_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(oreg_q));

endmodule

// File: rtl/nibdec_ctrl.sv
module nibdec_ctrl
    import nibdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       out_ready,
    input  logic       out_valid,
    input  byte_kind_e kind,
    output logic       in_ready,
    output logic       take,
    output logic       emit
);

    dec_state_e state_q;
    dec_state_e state_d;

    always_comb begin
        in_ready = (state_q != ST_FULL) || out_ready;
        take     = in_valid && in_ready;
        emit     = take && (kind == BK_PRIM || kind == BK_OPER);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_CHAIN: begin
                if (emit)      state_d = ST_FULL;
                else if (take) state_d = ST_CHAIN;
            end
            ST_FULL: begin
                if (out_ready) begin
                    if (emit)      state_d = ST_FULL;
                    else if (take) state_d = ST_CHAIN;
                    else           state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // R9: controller state and output register agree
    p_state_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) == out_valid);

    // R9: a drained record with nothing new behind it empties the output
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !emit |=> !out_valid);

    // R3: prefix bytes never raise a record
    p_chain_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take && (kind == BK_PFIX || kind == BK_NFIX) |=> !out_valid);

endmodule

// File: rtl/nibdec_outreg.sv
module nibdec_outreg
    import nibdec_pkg::*;
#(
    parameter int OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              out_ready,
    input  fcode_t            func,
    input  logic [OPND_W-1:0] operand,
    output logic              valid,
    output fcode_t            func_q,
    output logic [OPND_W-1:0] opnd_q,
    output logic              is_op
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            func_q <= '0;
            opnd_q <= '0;
            is_op  <= 1'b0;
        end else if (load) begin
            valid  <= 1'b1;
            func_q <= func;
            opnd_q <= operand;
            is_op  <= (func == FC_OPER);
        end else if (out_ready) begin
            valid  <= 1'b0;
        end
    end

    // R8: a stalled record does not move
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !out_ready |=> valid && $stable(func_q) && $stable(opnd_q) && $stable(is_op));

endmodule

// File: rtl/nibdec_top.sv
module nibdec_top
    import nibdec_pkg::*;
#(
    parameter int OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [3:0]        out_func,
    output logic [OPND_W-1:0] out_operand,
    output logic              out_is_op
);

    fcode_t            fcode;
    logic [NIB_W-1:0]  nib;
    byte_kind_e        kind;
    logic              take;
    logic              emit;
    logic [OPND_W-1:0] merged;

    assign fcode = in_byte[7:4];
    assign nib   = in_byte[3:0];
    assign kind  = classify(fcode);

    nibdec_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .kind      (kind),
        .in_ready  (in_ready),
        .take      (take),
        .emit      (emit)
    );

    nibdec_oper #(.OPND_W(OPND_W)) u_oper (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .kind   (kind),
        .nib    (nib),
        .merged (merged)
    );

    nibdec_outreg #(.OPND_W(OPND_W)) u_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (emit),
        .out_ready (out_ready),
        .func      (fcode),
        .operand   (merged),
        .valid     (out_valid),
        .func_q    (out_func),
        .opnd_q    (out_operand),
        .is_op     (out_is_op)
    );

    // R2: the function code of a completing byte reaches the record
    p_func_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && fcode != FC_PFIX && fcode != FC_NFIX
        |=> out_valid && out_func == $past(in_byte[7:4]));

    // R6: operate escapes are flagged, other codes are not
    p_opr_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && fcode != FC_PFIX && fcode != FC_NFIX
        |=> out_is_op == ($past(in_byte[7:4]) == 4'hF));

    // R10: a ready consumer never blocks input
    p_no_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);

endmodule

// File: tb/test_nibdec_top.sv
module test_nibdec_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [3:0]  out_func;
    logic [31:0] out_operand;
    logic        out_is_op;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    nibdec_top i_nibdec_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_byte     (in_byte),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_func    (out_func),
        .out_operand (out_operand),
        .out_is_op   (out_is_op)
    );

    // model state
    logic [31:0] m_oreg = '0;
    int          m_chain = 0;
    bit          m_neg = 0;
    bit          m_prev_chain = 0;
    logic [3:0]  q_func[$];
    logic [31:0] q_opnd[$];
    int          q_tag[$];

    function automatic string tagname(input int t);
        case (t)
            3: return "R3";
            4: return "R4";
            5: return "R5";
            7: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] r, input logic [3:0] n);
        return r | {28'd0, n};
    endfunction

    task automatic model_accept(input logic [7:0] b);
        logic [3:0]  f = b[7:4];
        logic [31:0] mg = merge(m_oreg, b[3:0]);
        int t;
        if (f == 4'h2) begin
            m_oreg = mg << 4; m_chain++;
        end else if (f == 4'h6) begin
            m_oreg = (~mg) << 4; m_chain++; m_neg = 1;
        end else begin
            if (m_neg)              t = 4;
            else if (m_chain > 7)   t = 5;
            else if (m_chain > 0)   t = 3;
            else if (m_prev_chain)  t = 7;
            else                    t = 2;
            q_func.push_back(f);
            q_opnd.push_back(mg);
            q_tag.push_back(t);
            m_prev_chain = (m_chain > 0);
            m_oreg = '0; m_chain = 0; m_neg = 0;
        end
    endtask

    // drive one cycle at a negedge; records both handshakes of the coming edge
    task automatic cyc(input bit v, input logic [7:0] b, input bit r, output bit fired);
        logic [3:0]  ef;
        logic [31:0] eo;
        int          et;
        in_valid = v; in_byte = b; out_ready = r;
        #1;
        fired = v && in_ready;
        if (out_valid && r) begin
            if (q_func.size() == 0) begin
                chk(0, "R9", {28'd0, out_func}, 32'hDEAD);
            end else begin
                ef = q_func.pop_front();
                eo = q_opnd.pop_front();
                et = q_tag.pop_front();
                chk(out_func == ef, tagname(et), {28'd0, out_func}, {28'd0, ef});
                chk(out_operand == eo, tagname(et), out_operand, eo);
                chk(out_is_op == (ef == 4'hF), "R6", {31'd0, out_is_op}, {31'd0, ef == 4'hF});
            end
        end
        if (fired) model_accept(b);
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        bit f;
        do cyc(1, b, 1, f); while (!f);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", total);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit f;
        logic [7:0] pend;
        bit         have;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
        chk(in_ready == 1'b1, "R1", {31'd0, in_ready}, 32'd1);

        // R2 / R1: first byte carries only its nibble; then stall for R8
        cyc(1, 8'h47, 0, f);
        chk(out_valid == 1'b1 && out_operand == 32'h7, "R2", out_operand, 32'h7);
        cyc(0, 8'h00, 0, f);
        chk(in_ready == 1'b0, "R8", {31'd0, in_ready}, 32'd0);
        cyc(1, 8'h55, 0, f);
        chk(f == 1'b0, "R8", {31'd0, f}, 32'd0);
        chk(out_func == 4'h4 && out_operand == 32'h7, "R8", out_operand, 32'h7);
        cyc(0, 8'h00, 1, f);
        // R9: consumed with nothing behind it
        chk(out_valid == 1'b0, "R9", {31'd0, out_valid}, 32'd0);

        // R3: prefix chain 0x123
        send(8'h21); send(8'h22);
        chk(out_valid == 1'b0, "R3", {31'd0, out_valid}, 32'd0);
        send(8'h43);
        // R7: next plain byte carries only its nibble
        send(8'h83);
        // R4: negative prefix gives -1
        send(8'h60); send(8'h4F);
        // R6: operate escape with secondary code 0x42
        send(8'h24); send(8'hF2);
        // R5: long chain, high bits discarded
        for (int i = 0; i < 9; i++) send(8'h2F);
        send(8'h4F);

        // R10: back-to-back completing bytes with ready consumer
        for (int i = 1; i <= 8; i++) begin
            cyc(1, {4'h1, i[3:0]}, 1, f);
            chk(f == 1'b1, "R10", {31'd0, f}, 32'd1);
        end
        cyc(0, 8'h00, 1, f);

        // random phase
        have = 0; pend = '0;
        for (int c = 0; c < 4000; c++) begin
            int p;
            if (!have && ($urandom % 10) < 7) begin
                p = $urandom % 10;
                if (p < 3)      pend = {4'h2, 4'($urandom)};
                else if (p < 4) pend = {4'h6, 4'($urandom)};
                else            pend = 8'($urandom);
                have = 1;
            end
            cyc(have, pend, (($urandom % 10) < 6), f);
            if (f) have = 0;
        end
        // finish any pending byte, then drain
        while (have) begin
            cyc(1, pend, 1, f);
            if (f) have = 0;
        end
        if (m_chain > 0) send(8'h40);
        repeat (4) cyc(0, 8'h00, 1, f);
        chk(q_func.size() == 0, "R9", q_func.size(), 32'd0);
        chk(out_valid == 1'b0, "R9", {31'd0, out_valid}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule